// File: doc/BRIEF.md
# PLL Lock Supervisor with Backup Clock Selection

This block watches the lock indication of a phase-locked loop and decides which source feeds the system clock: the PLL or a slower backup oscillator. The lock indication arrives asynchronously. The block synchronizes it and turns every change of lock state into an event. From these events it derives a lock-change interrupt, a reset request when lock is lost in normal operation, and a gate that holds the PLL clock off until lock returns.

The source choice comes from a backup-request bit and a limp-mode enable. Software normally owns the backup-request bit. While hard reset is active, however, hardware drives the bit: it is set while the PLL is unlocked and cleared once lock is seen. The backup source is chosen only when both the request bit and limp-mode enable are set. The choice leaves the block from a register, so an external glitch-free clock multiplexer can consume it directly.

Top module: `pll_lock_supervisor`

## Requirements
- R1: While `rst_ni` is low, the outputs take these values: `src_sel_o`=0 (PLL), `pll_out_en_o`=1, `rst_req_o`=0, `irq_o`=0, `bkup_req_o`=0 and `irq_flag_o`=0.
- R2: `lock_raw_i` passes through a synchronizer of `SYNC_STAGES` flops (default 2) before it is used. A change sampled at one rising edge first shows on `irq_flag_o` after the third rising edge, and not before.
- R3: Outside hard reset, a cycle with `bkup_wr_i`=1 loads `bkup_wdata_i` into the backup-request bit. The bit reads back on `bkup_req_o` after the next edge.
- R4: While `hard_rst_i`=1, the backup-request bit is set when the synchronized lock is 0 and cleared when it is 1. Software writes are ignored during this time.
- R5: `src_sel_o` is 1 (backup) exactly one edge after the backup-request bit and `limp_en_i` are both 1. Otherwise it is 0 (PLL).
- R6: When the synchronized lock falls while `hard_rst_i`=0 and `lol_rst_en_i`=1, `rst_req_o` goes high for exactly one cycle. A rising lock, an active hard reset or a cleared enable produces no request.
- R7: `pll_out_en_o` goes to 0 in the same cycle as a reset request from R6. It stays 0 until the synchronized lock is 1 again, and returns to 1 one edge later.
- R8: Every rising or falling change of the synchronized lock sets the sticky `irq_flag_o`.
- R9: `irq_clr_i`=1 clears the flag (write-one-to-clear). When a new lock change and a clear fall in the same cycle, the flag ends up set.
- R10: `irq_o` is 1 exactly when the flag and `irq_mask_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| lock_raw_i | input | 1 | Asynchronous PLL lock indication |
| hard_rst_i | input | 1 | Hard reset in progress |
| bkup_wr_i | input | 1 | Software write strobe for the backup-request bit |
| bkup_wdata_i | input | 1 | Value written to the backup-request bit |
| limp_en_i | input | 1 | Limp-mode enable; allows the backup source |
| lol_rst_en_i | input | 1 | Enables a reset request on loss of lock |
| irq_mask_i | input | 1 | 1 lets the flag reach the interrupt output |
| irq_clr_i | input | 1 | Write-one-to-clear for the lock-change flag |
| src_sel_o | output | 1 | Registered clock source select, 1 = backup |
| pll_out_en_o | output | 1 | PLL output clock enable |
| rst_req_o | output | 1 | One-cycle hard-reset request |
| irq_o | output | 1 | Masked lock-change interrupt |
| bkup_req_o | output | 1 | Readback of the backup-request bit |
| irq_flag_o | output | 1 | Readback of the sticky lock-change flag |

## Verification
Two pairs of functions can collide in one cycle. The first pair is the arrival of a lock-change event and a software clear of the flag. The bench holds the clear high while a lock edge crosses the synchronizer, then checks that the flag is 1 right after the event edge and 0 one edge later. The second pair is hard-reset ownership of the backup-request bit and a software write to it. The bench writes the opposite value while hard reset is active and checks that the hardware value survives. In both cases the sampling cycle comes from the three-edge synchronizer latency.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

   // Edge events of the synchronized lock level
   typedef struct packed {
      logic rise;
      logic fall;
   } lock_evt_t;

   typedef enum logic {
      SRC_PLL    = 1'b0,
      SRC_BACKUP = 1'b1
   } clk_src_e;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync
   import pll_sup_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      lock_raw_i,
   output logic      lock_o,
   output lock_evt_t evt_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pll_lock_sync: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;
   logic          prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[LAST-1:0], lock_raw_i};
         prev_q  <= chain_q[LAST];
      end
   end

   assign lock_o     = chain_q[LAST];
   assign evt_o.rise = chain_q[LAST] & ~prev_q;
   assign evt_o.fall = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/pll_src_ctrl.sv
module pll_src_ctrl
   import pll_sup_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     hard_rst_i,
   input  logic     lock_i,
   input  logic     wr_i,
   input  logic     wdata_i,
   input  logic     limp_en_i,
   output logic     bkup_o,
   output clk_src_e src_o
);

   logic     bkup_q;
   logic     bkup_d;
   clk_src_e src_q;

   // Hard reset gives hardware ownership of the request bit
   always_comb begin
      bkup_d = bkup_q;
      if (hard_rst_i) begin
         bkup_d = ~lock_i;
      end else if (wr_i) begin
         bkup_d = wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bkup_q <= 1'b0;
         src_q  <= SRC_PLL;
      end else begin
         bkup_q <= bkup_d;
         src_q  <= (bkup_q && limp_en_i) ? SRC_BACKUP : SRC_PLL;
      end
   end

   assign bkup_o = bkup_q;
   assign src_o  = src_q;

endmodule

// File: rtl/pll_lol_ctrl.sv
module pll_lol_ctrl
   import pll_sup_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      hard_rst_i,
   input  logic      lol_en_i,
   input  logic      lock_i,
   input  lock_evt_t evt_i,
   output logic      rst_req_o,
   output logic      out_en_o
);

   logic req_d;
   logic req_q;
   logic gate_q;

   assign req_d = evt_i.fall & lol_en_i & ~hard_rst_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_q  <= 1'b0;
         gate_q <= 1'b0;
      end else begin
         req_q <= req_d;
         if (lock_i) begin
            gate_q <= 1'b0;
         end else if (req_d) begin
            gate_q <= 1'b1;
         end
      end
   end

   assign rst_req_o = req_q;
   assign out_en_o  = ~gate_q;

endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq
   import pll_sup_pkg::*;
#(
   parameter bit IRQ_ON_RISE = 1'b1,
   parameter bit IRQ_ON_FALL = 1'b1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  lock_evt_t evt_i,
   input  logic      clr_i,
   input  logic      mask_i,
   output logic      flag_o,
   output logic      irq_o
);

   if (!IRQ_ON_RISE && !IRQ_ON_FALL) begin : g_bad_edges
      $error("pll_lock_irq: at least one edge must raise the flag");
   end

   logic hit;

   if (IRQ_ON_RISE && IRQ_ON_FALL) begin : g_both
      assign hit = evt_i.rise | evt_i.fall;
   end else if (IRQ_ON_RISE) begin : g_rise
      assign hit = evt_i.rise;
   end else begin : g_fall
      assign hit = evt_i.fall;
   end

   logic flag_q;

   // A new event outranks a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (hit) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & mask_i;

endmodule

// File: rtl/pll_lock_supervisor.sv
module pll_lock_supervisor
   import pll_sup_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_ON_RISE = 1'b1,
   parameter bit IRQ_ON_FALL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lock_raw_i,
   input  logic hard_rst_i,
   input  logic bkup_wr_i,
   input  logic bkup_wdata_i,
   input  logic limp_en_i,
   input  logic lol_rst_en_i,
   input  logic irq_mask_i,
   input  logic irq_clr_i,
   output logic src_sel_o,
   output logic pll_out_en_o,
   output logic rst_req_o,
   output logic irq_o,
   output logic bkup_req_o,
   output logic irq_flag_o
);

   logic      lock_sync;
   lock_evt_t lock_evt;
   clk_src_e  src;

   pll_lock_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lock_raw_i (lock_raw_i),
      .lock_o     (lock_sync),
      .evt_o      (lock_evt)
   );

   pll_src_ctrl u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hard_rst_i (hard_rst_i),
      .lock_i     (lock_sync),
      .wr_i       (bkup_wr_i),
      .wdata_i    (bkup_wdata_i),
      .limp_en_i  (limp_en_i),
      .bkup_o     (bkup_req_o),
      .src_o      (src)
   );

   pll_lol_ctrl u_lol (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hard_rst_i (hard_rst_i),
      .lol_en_i   (lol_rst_en_i),
      .lock_i     (lock_sync),
      .evt_i      (lock_evt),
      .rst_req_o  (rst_req_o),
      .out_en_o   (pll_out_en_o)
   );

   pll_lock_irq #(
      .IRQ_ON_RISE (IRQ_ON_RISE),
      .IRQ_ON_FALL (IRQ_ON_FALL)
   ) u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (lock_evt),
      .clr_i  (irq_clr_i),
      .mask_i (irq_mask_i),
      .flag_o (irq_flag_o),
      .irq_o  (irq_o)
   );

   assign src_sel_o = (src == SRC_BACKUP);

endmodule

// File: rtl/pll_lock_supervisor_chk.sv
module pll_lock_supervisor_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic hard_rst_i,
   input logic limp_en_i,
   input logic lol_rst_en_i,
   input logic irq_clr_i,
   input logic src_sel_o,
   input logic pll_out_en_o,
   input logic rst_req_o,
   input logic bkup_req_o,
   input logic irq_flag_o,
   input logic lock_sync
);

   // R4: hardware owns the request bit during hard reset
   p_hw_sets_bkup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_rst_i && !lock_sync |=> bkup_req_o);

   p_hw_clears_bkup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hard_rst_i && lock_sync |=> !bkup_req_o);

   // R5: backup source only with both enables one edge earlier
   p_sel_needs_limp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_sel_o |-> $past(bkup_req_o && limp_en_i));

   // R6: request is a single-cycle pulse with its qualifiers
   p_req_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o);

   p_req_qualified_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> $past(lol_rst_en_i && !hard_rst_i));

   // R7: output clock gated whenever a request is issued
   p_gate_on_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> !pll_out_en_o);

   // R8: a synchronized rise sets the flag on the following edge
   p_rise_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_sync) |=> irq_flag_o);

   // R9: flag holds unless cleared
   p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_flag_o && !irq_clr_i |=> irq_flag_o);

endmodule

bind pll_lock_supervisor pll_lock_supervisor_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .hard_rst_i   (hard_rst_i),
   .limp_en_i    (limp_en_i),
   .lol_rst_en_i (lol_rst_en_i),
   .irq_clr_i    (irq_clr_i),
   .src_sel_o    (src_sel_o),
   .pll_out_en_o (pll_out_en_o),
   .rst_req_o    (rst_req_o),
   .bkup_req_o   (bkup_req_o),
   .irq_flag_o   (irq_flag_o),
   .lock_sync    (lock_sync)
);

// File: tb/pll_lock_supervisor_bench.sv
module pll_lock_supervisor_bench;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic lock_raw, hard_rst, bkup_wr, bkup_wdata, limp_en, lol_en, mask, clr;
   logic src_sel, pll_en, rst_req, irq, bkup, flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pll_lock_supervisor u_pll_lock_supervisor (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .lock_raw_i   (lock_raw),
      .hard_rst_i   (hard_rst),
      .bkup_wr_i    (bkup_wr),
      .bkup_wdata_i (bkup_wdata),
      .limp_en_i    (limp_en),
      .lol_rst_en_i (lol_en),
      .irq_mask_i   (mask),
      .irq_clr_i    (clr),
      .src_sel_o    (src_sel),
      .pll_out_en_o (pll_en),
      .rst_req_o    (rst_req),
      .irq_o        (irq),
      .bkup_req_o   (bkup),
      .irq_flag_o   (flag)
   );

   // inputs {hard_rst,wr,wdata,limp,lol,mask,clr,lock} , expect {sel,pen,bkup,flag,irq}
   localparam logic [12:0] VEC [0:13] = '{
      {8'b0000_0001, 5'b01010},
      {8'b0000_0101, 5'b01011},
      {8'b0000_0111, 5'b01000},
      {8'b0110_0001, 5'b01100},
      {8'b0001_0001, 5'b11100},
      {8'b0101_0001, 5'b01000},
      {8'b1001_0001, 5'b01000},
      {8'b1001_1000, 5'b11110},
      {8'b1101_0000, 5'b11110},
      {8'b1001_0011, 5'b01000},
      {8'b0000_0000, 5'b01010},
      {8'b0000_1001, 5'b01010},
      {8'b0000_1000, 5'b00010},
      {8'b0000_1101, 5'b01011}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] v);
      {hard_rst, bkup_wr, bkup_wdata, limp_en, lol_en, mask, clr, lock_raw} = v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      drive(8'h00);
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);

      // table walk, each vector held five edges to settle
      for (int i = 0; i < 14; i++) begin
         drive(VEC[i][12:5]);
         repeat (5) step();
         chk($sformatf("R3/R4/R5/R7/R8/R9/R10 vector %0d", i),
             {3'b0, src_sel, pll_en, bkup, flag, irq}, {3'b0, VEC[i][4:0]});
      end

      // R1: reset clears everything, mask held high
      drive(8'b0111_0100);
      step();
      bkup_wr = 1'b0;
      step();
      rst_ni = 1'b0;
      drive(8'b0001_0100);
      step();
      chk("R1 reset state", {2'b0, src_sel, pll_en, rst_req, irq, bkup, flag},
          8'b0001_0000);
      rst_ni = 1'b1;
      step();

      // R2: three-edge latency through the synchronizer
      lock_raw = 1'b1;
      step();
      step();
      chk("R2 no flag after two edges", {7'b0, flag}, 8'd0);
      step();
      chk("R2 flag after third edge", {7'b0, flag}, 8'd1);
      chk("R10 irq follows mask", {7'b0, irq}, 8'd1);

      // R9: clear against a simultaneous event
      clr = 1'b1;
      step();
      chk("R9 clear", {7'b0, flag}, 8'd0);
      lock_raw = 1'b0;
      step();
      step();
      chk("R9 before event", {7'b0, flag}, 8'd0);
      step();
      chk("R9 event beats clear", {7'b0, flag}, 8'd1);
      step();
      chk("R9 clear after event", {7'b0, flag}, 8'd0);
      clr = 1'b0;

      // R6: rise never requests reset
      lol_en = 1'b1;
      lock_raw = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R6 no request on rise", {7'b0, rst_req}, 8'd0);
      end

      // R6/R7: loss of lock outside hard reset
      lock_raw = 1'b0;
      step();
      step();
      chk("R6 no early request", {7'b0, rst_req}, 8'd0);
      step();
      chk("R6 request pulse", {7'b0, rst_req}, 8'd1);
      chk("R7 clock gated", {7'b0, pll_en}, 8'd0);
      step();
      chk("R6 pulse one cycle", {7'b0, rst_req}, 8'd0);
      chk("R7 gate held while unlocked", {7'b0, pll_en}, 8'd0);
      lock_raw = 1'b1;
      step();
      step();
      chk("R7 gate until lock synced", {7'b0, pll_en}, 8'd0);
      step();
      chk("R7 clock restored", {7'b0, pll_en}, 8'd1);
      lol_en = 1'b0;

      // R3/R5: write latency then select latency
      limp_en = 1'b1;
      bkup_wr = 1'b1;
      bkup_wdata = 1'b1;
      step();
      bkup_wr = 1'b0;
      chk("R3 write readback", {6'b0, bkup, src_sel}, 8'b10);
      step();
      chk("R5 select one edge later", {7'b0, src_sel}, 8'd1);
      limp_en = 1'b0;
      step();
      chk("R5 limp disable returns to PLL", {6'b0, bkup, src_sel}, 8'b10);

      // R4: write during hard reset ignored while locked
      hard_rst = 1'b1;
      step();
      chk("R4 cleared when locked", {7'b0, bkup}, 8'd0);
      bkup_wr = 1'b1;
      bkup_wdata = 1'b1;
      step();
      step();
      chk("R4 write ignored in hard reset", {7'b0, bkup}, 8'd0);
      drive(8'h01);
      step();

      finish_run();
   end

endmodule